// File: doc/BRIEF.md
# Core-to-Host Message Mailbox

This block passes 32-bit messages between a local compute core and a host on a memory-mapped register port. Traffic toward the core goes through a four-deep inbound queue that the host fills and the core drains, oldest first. Traffic toward the host goes through two single-word outbound mailboxes that the core fills and the host drains. One of them is plain. The other can raise an interrupt toward the host when the core deposits a word.

The core reaches the mailboxes through a channel port. Each request carries an operation (read, write or count query) and a channel number. While a request cannot complete, the block raises `ch_stall` combinationally in the same cycle. The core holds the request until the stall drops, and the access then takes effect on that clock edge. Count queries never stall, so the core can poll before it commits to a blocking access.

On the host side there are one-cycle read and write strobes, a two-bit register select, and a combinational read-data bus. The same port also reaches a control register that holds four enable bits and a status word. A sticky event flag goes toward the core and a sticky interrupt flag goes toward the host. Each flag is cleared by a pulse on its own acknowledge input.

Top module: `mbox_unit`

## Requirements
- R1: Inbound messages are 32 bits wide. The inbound queue holds up to four, and core reads (op 0 on channel 0) return them in the order the host wrote them to register 0.
- R2: Each host write to register 0 raises the inbound count by one, and each completed core read of channel 0 lowers it by one. A count query (op 2) on channel 0 returns that count on `ch_rdata` without stalling.
- R3: A host write while four entries are held leaves the count at four and replaces the newest slot. For example, writes a,b,c,d,e with no read in between are later read as a,b,c,e.
- R4: A core read of channel 0 while the queue is empty holds `ch_stall` high until a host write arrives. The cycle after that write, the stall drops and `ch_rdata` carries the written word.
- R5: A core write (op 1) to channel 1 or 2 while that mailbox is full holds `ch_stall` high until a host read of register 1 or 2 empties it. A count query on channel 1 or 2 returns 1 when empty and 0 when full.
- R6: A host read of an outbound register returns the held word and empties the mailbox. A host read of an empty outbound register returns the last word again and changes no state.
- R7: `evt` is sticky. It is set by a host write to register 0 when enable bit 0 is set, by a host read that empties mailbox 1 when enable bit 1 is set, or by a host read that empties mailbox 2 when enable bit 2 is set. A pulse on `evt_ack` clears it. A source whose enable bit is clear does not set it.
- R8: `irq` is sticky. It is set when a core write lands in mailbox 2 while enable bit 3 is set, and a pulse on `irq_ack` clears it. With bit 3 clear, such a write leaves `irq` low.
- R9: A host write to register 3 loads the enables from `h_wdata[3:0]`. A host read of register 3 returns the status word: bits [2:0] inbound count, bit 4 mailbox 1 full, bit 5 mailbox 2 full, bits [11:8] enables, other bits 0.
- R10: After reset the queue and both mailboxes are empty, the enables are zero, and `evt`, `irq` and `ch_stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req | input | 1 | Core channel request, held until not stalled |
| ch_op | input | 2 | 0 read, 1 write, 2 count query |
| ch_sel | input | 2 | 0 inbound queue, 1 plain outbound, 2 interrupt outbound |
| ch_wdata | input | 32 | Core write data |
| ch_rdata | output | 32 | Core read data or count value |
| ch_stall | output | 1 | Request cannot complete this cycle |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 2 | 0 inbound, 1 plain outbound, 2 interrupt outbound, 3 control/status |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data |
| evt | output | 1 | Sticky event toward the core |
| evt_ack | input | 1 | Clears `evt` |
| irq | output | 1 | Sticky interrupt toward the host |
| irq_ack | input | 1 | Clears `irq` |

## Verification
The bench fills the inbound queue past four entries and then reads it back. A design that kept a fifth slot or dropped the newest word would return the wrong fourth word or a count of five. It parks a core read on an empty queue and a core write on a full mailbox, then releases each with the matching host access. A stall that clears too early or never clears shows up as a wrong word or a hung request. It also reads an already-empty outbound register and raises each flag source with its enable both clear and set. A design that wipes the held word, or that raises a flag regardless of its enable, is caught by the status word and the flag outputs.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_COUNT = 2'd2;

  localparam logic [1:0] SEL_IN   = 2'd0;
  localparam logic [1:0] SEL_OUT0 = 2'd1;

  localparam logic [1:0] HA_IN    = 2'd0;
  localparam logic [1:0] HA_OUT0  = 2'd1;
  localparam logic [1:0] HA_CTRL  = 2'd3;

  localparam int EN_W = 4;

  // slot that receives a host word; a pop shifts everything down first
  function automatic int fifo_slot(int cnt, logic pop, int depth);
    if (pop)             return (cnt > 0) ? cnt - 1 : 0;
    else if (cnt >= depth) return depth - 1;
    else                 return cnt;
  endfunction

  // occupancy after one cycle; a push into a full queue replaces, not grows
  function automatic int fifo_next(int cnt, logic push, logic pop, int depth);
    int n;
    n = cnt;
    if (pop && cnt > 0) n = n - 1;
    if (push && n < depth) n = n + 1;
    return n;
  endfunction

  function automatic logic [31:0] pack_status(logic [2:0] cnt, logic v0,
                                              logic v1, logic [EN_W-1:0] en);
    return {20'd0, en, 2'b00, v1, v0, 1'b0, cnt};
  endfunction

endpackage

// File: rtl/mbox_in_fifo.sv
module mbox_in_fifo
  import mbox_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] wr_idx;

  always_comb wr_idx = IW'(fifo_slot(int'(count), pop, DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
      end
      if (push) mem[wr_idx] <= push_data;
      count <= CW'(fifo_next(int'(count), push, pop, DEPTH));
    end
  end

  assign head = mem[0];

endmodule

// File: rtl/mbox_out_slot.sv
module mbox_out_slot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill,
  input  logic [DW-1:0] fill_data,
  input  logic          take,
  output logic [DW-1:0] data,
  output logic          valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (fill) begin
      valid <= 1'b1;
      data  <= fill_data;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mbox_sticky.sv
module mbox_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (ack) flag <= 1'b0;
  end

endmodule

// File: rtl/mbox_unit.sv
module mbox_unit
  import mbox_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int NOUT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_req,
  input  logic [1:0]    ch_op,
  input  logic [1:0]    ch_sel,
  input  logic [DW-1:0] ch_wdata,
  output logic [DW-1:0] ch_rdata,
  output logic          ch_stall,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic [1:0]    h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          evt,
  input  logic          evt_ack,
  output logic          irq,
  input  logic          irq_ack
);

  // named internal events
  logic            core_rd_in, in_push, in_pop, cfg_we;
  logic [CW-1:0]   in_cnt;
  logic [DW-1:0]   in_head;
  logic [NOUT-1:0] core_wr_out, out_valid, out_fill, out_take;
  logic [DW-1:0]   out_data [NOUT];
  logic [EN_W-1:0] en;
  logic            evt_set, irq_set;
  logic [31:0]     status;

  assign core_rd_in = ch_req && (ch_op == OP_READ) && (ch_sel == SEL_IN);
  assign in_pop     = core_rd_in && (in_cnt != '0);
  assign in_push    = h_wr && (h_addr == HA_IN);
  assign cfg_we     = h_wr && (h_addr == HA_CTRL);

  mbox_in_fifo #(.DW(DW), .DEPTH(DEPTH)) u_in (
    .clk(clk), .rst_n(rst_n),
    .push(in_push), .push_data(h_wdata),
    .pop(in_pop), .head(in_head), .count(in_cnt)
  );

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    assign core_wr_out[k] = ch_req && (ch_op == OP_WRITE)
                            && (ch_sel == 2'(SEL_OUT0 + k));
    assign out_fill[k]    = core_wr_out[k] && !out_valid[k];
    assign out_take[k]    = h_rd && (h_addr == 2'(HA_OUT0 + k)) && out_valid[k];

    mbox_out_slot #(.DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .fill(out_fill[k]), .fill_data(ch_wdata),
      .take(out_take[k]),
      .data(out_data[k]), .valid(out_valid[k])
    );
  end

  assign ch_stall = (core_rd_in && (in_cnt == '0)) || |(core_wr_out & out_valid);

  always_ff @(posedge clk) begin
    if (!rst_n)      en <= '0;
    else if (cfg_we) en <= h_wdata[EN_W-1:0];
  end

  assign evt_set = (in_push && en[0]) || (out_take[0] && en[1])
                   || (out_take[1] && en[2]);
  assign irq_set = out_fill[NOUT-1] && en[3];

  mbox_sticky u_evt (.clk(clk), .rst_n(rst_n), .set(evt_set), .ack(evt_ack), .flag(evt));
  mbox_sticky u_irq (.clk(clk), .rst_n(rst_n), .set(irq_set), .ack(irq_ack), .flag(irq));

  assign status = pack_status(3'(in_cnt), out_valid[0], out_valid[1], en);

  always_comb begin
    ch_rdata = '0;
    if (ch_op == OP_READ && ch_sel == SEL_IN) begin
      ch_rdata = in_head;
    end else if (ch_op == OP_COUNT) begin
      if (ch_sel == SEL_IN) ch_rdata = DW'(in_cnt);
      for (int k = 0; k < NOUT; k++)
        if (ch_sel == 2'(SEL_OUT0 + k)) ch_rdata = DW'(!out_valid[k]);
    end
  end

  always_comb begin
    h_rdata = '0;
    if (h_addr == HA_CTRL) h_rdata = DW'(status);
    for (int k = 0; k < NOUT; k++)
      if (h_addr == 2'(HA_OUT0 + k)) h_rdata = out_data[k];
  end

endmodule

// File: rtl/mbox_unit_chk.sv
module mbox_unit_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ch_req,
  input logic [1:0]    ch_op,
  input logic [1:0]    ch_sel,
  input logic          ch_stall,
  input logic          evt,
  input logic          evt_ack,
  input logic          irq,
  input logic          irq_set,
  input logic [CW-1:0] in_cnt,
  input logic          in_push,
  input logic          in_pop,
  input logic [1:0]    out_valid
);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= CW'(DEPTH));

  p_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_push && !in_pop && in_cnt == CW'(DEPTH)) |=> in_cnt == CW'(DEPTH));

  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_push && !in_pop && in_cnt < CW'(DEPTH)) |=> in_cnt == CW'($past(in_cnt) + 1'b1));

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pop && !in_push) |=> in_cnt == CW'($past(in_cnt) - 1'b1));

  p_query_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_req && ch_op == 2'd2) |-> !ch_stall);

  p_empty_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_req && ch_op == 2'd0 && ch_sel == 2'd0 && in_cnt == '0) |-> ch_stall);

  p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_req && ch_op == 2'd1 && ch_sel == 2'd2 && out_valid[1]) |-> ch_stall);

  p_evt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !evt_ack) |=> evt);

  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq);

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !irq_set) |=> !irq);

endmodule

bind mbox_unit mbox_unit_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_op(ch_op), .ch_sel(ch_sel),
  .ch_stall(ch_stall), .evt(evt), .evt_ack(evt_ack), .irq(irq),
  .irq_set(irq_set), .in_cnt(in_cnt), .in_push(in_push), .in_pop(in_pop),
  .out_valid(out_valid)
);

// File: tb/mbox_unit_test.sv
`timescale 1ns/1ps
module mbox_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ch_req = 1'b0;
  logic [1:0]  ch_op = 2'd0, ch_sel = 2'd0, h_addr = 2'd0;
  logic [31:0] ch_wdata = '0, h_wdata = '0;
  logic [31:0] ch_rdata, h_rdata;
  logic        ch_stall, evt, irq;
  logic        h_wr = 1'b0, h_rd = 1'b0, evt_ack = 1'b0, irq_ack = 1'b0;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  mbox_unit uut (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_op(ch_op), .ch_sel(ch_sel),
    .ch_wdata(ch_wdata), .ch_rdata(ch_rdata), .ch_stall(ch_stall),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .evt(evt), .evt_ack(evt_ack), .irq(irq), .irq_ack(irq_ack)
  );

  function automatic logic [31:0] exp_status(int cnt, bit f1, bit f2, logic [3:0] en);
    logic [31:0] s;
    s = 32'(cnt) & 32'h7;
    s[4] = f1;
    s[5] = f2;
    s[11:8] = en;
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); h_addr = a; h_rd = 1'b1;
    #1 d = h_rdata;
    @(negedge clk); h_rd = 1'b0;
  endtask

  task automatic core_count(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); ch_req = 1'b1; ch_op = 2'd2; ch_sel = s;
    #1 v = ch_rdata;
    chk(ch_stall == 1'b0, "R2 count query stalled", 32'(ch_stall), 0);
    @(negedge clk); ch_req = 1'b0;
  endtask

  task automatic core_rd(output logic [31:0] d);
    @(negedge clk); ch_req = 1'b1; ch_op = 2'd0; ch_sel = 2'd0;
    #1;
    while (ch_stall) begin @(negedge clk); #1; end
    d = ch_rdata;
    @(negedge clk); ch_req = 1'b0;
  endtask

  task automatic core_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); ch_req = 1'b1; ch_op = 2'd1; ch_sel = s; ch_wdata = d;
    #1;
    while (ch_stall) begin @(negedge clk); #1; end
    @(negedge clk); ch_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    #1;
    chk(ch_stall == 0 && evt == 0 && irq == 0, "R10 outputs after reset",
        {29'd0, ch_stall, evt, irq}, 0);
    host_rd(2'd3, v);
    chk(v == 32'h0, "R10 status after reset", v, 0);
    core_count(2'd0, v);
    chk(v == 0, "R10 inbound count after reset", v, 0);
    core_count(2'd1, v);
    chk(v == 1, "R10 outbound1 empty after reset", v, 1);
    core_count(2'd2, v);
    chk(v == 1, "R10 outbound2 empty after reset", v, 1);
  endtask

  task automatic t_order();
    logic [31:0] v;
    host_wr(2'd0, 32'hA0A0_0001);
    host_wr(2'd0, 32'hB1B1_0002);
    host_wr(2'd0, 32'hC2C2_0003);
    core_count(2'd0, v);
    chk(v == 3, "R2 count after three writes", v, 3);
    host_rd(2'd3, v);
    chk(v == exp_status(3, 0, 0, 4'h0), "R9 status count field", v, exp_status(3, 0, 0, 4'h0));
    core_rd(v); chk(v == 32'hA0A0_0001, "R1 first word", v, 32'hA0A0_0001);
    core_count(2'd0, v);
    chk(v == 2, "R2 count after one read", v, 2);
    core_rd(v); chk(v == 32'hB1B1_0002, "R1 second word", v, 32'hB1B1_0002);
    core_rd(v); chk(v == 32'hC2C2_0003, "R1 third word", v, 32'hC2C2_0003);
    core_count(2'd0, v);
    chk(v == 0, "R2 count drained", v, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    logic [31:0] exp [4];
    for (int i = 0; i < 5; i++) host_wr(2'd0, 32'h5000_0000 + 32'(i));
    core_count(2'd0, v);
    chk(v == 4, "R3 count saturates at four", v, 4);
    exp[0] = 32'h5000_0000; exp[1] = 32'h5000_0001;
    exp[2] = 32'h5000_0002; exp[3] = 32'h5000_0004;
    for (int i = 0; i < 4; i++) begin
      core_rd(v);
      chk(v == exp[i], "R3 read order after overflow", v, exp[i]);
    end
    core_count(2'd0, v);
    chk(v == 0, "R3 empty after four reads", v, 0);
  endtask

  task automatic t_empty_stall();
    logic [31:0] v;
    @(negedge clk); ch_req = 1'b1; ch_op = 2'd0; ch_sel = 2'd0;
    for (int i = 0; i < 3; i++) begin
      #1 chk(ch_stall == 1'b1, "R4 stall on empty read", 32'(ch_stall), 1);
      @(negedge clk);
    end
    h_addr = 2'd0; h_wdata = 32'hDEAD_0444; h_wr = 1'b1;
    #1 chk(ch_stall == 1'b1, "R4 stall holds until write lands", 32'(ch_stall), 1);
    @(negedge clk); h_wr = 1'b0;
    #1 chk(ch_stall == 1'b0, "R4 stall released", 32'(ch_stall), 0);
    chk(ch_rdata == 32'hDEAD_0444, "R4 released read data", ch_rdata, 32'hDEAD_0444);
    @(negedge clk); ch_req = 1'b0;
    core_count(2'd0, v);
    chk(v == 0, "R4 read consumed the word", v, 0);
  endtask

  task automatic t_outbound();
    logic [31:0] v;
    core_wr(2'd1, 32'h0B0B_1111);
    core_count(2'd1, v);
    chk(v == 0, "R5 count reports full", v, 0);
    host_rd(2'd3, v);
    chk(v == exp_status(0, 1, 0, 4'h0), "R9 status full flag", v, exp_status(0, 1, 0, 4'h0));
    @(negedge clk); ch_req = 1'b1; ch_op = 2'd1; ch_sel = 2'd1; ch_wdata = 32'h0C0C_2222;
    for (int i = 0; i < 3; i++) begin
      #1 chk(ch_stall == 1'b1, "R5 stall on full write", 32'(ch_stall), 1);
      @(negedge clk);
    end
    h_addr = 2'd1; h_rd = 1'b1;
    #1 chk(h_rdata == 32'h0B0B_1111, "R6 host reads held word", h_rdata, 32'h0B0B_1111);
    @(negedge clk); h_rd = 1'b0;
    #1 chk(ch_stall == 1'b0, "R5 stall released by host read", 32'(ch_stall), 0);
    @(negedge clk); ch_req = 1'b0;
    host_rd(2'd1, v);
    chk(v == 32'h0C0C_2222, "R5 stalled write landed", v, 32'h0C0C_2222);
    host_rd(2'd1, v);
    chk(v == 32'h0C0C_2222, "R6 empty read returns last word", v, 32'h0C0C_2222);
    host_rd(2'd3, v);
    chk(v == exp_status(0, 0, 0, 4'h0), "R6 empty read leaves state", v, exp_status(0, 0, 0, 4'h0));
    core_count(2'd1, v);
    chk(v == 1, "R5 count reports empty", v, 1);
  endtask

  task automatic t_flags();
    logic [31:0] v;
    host_wr(2'd0, 32'h1);
    #1 chk(evt == 1'b0, "R7 disabled source leaves evt low", 32'(evt), 0);
    core_rd(v);
    host_wr(2'd3, 32'h1);
    host_rd(2'd3, v);
    chk(v == exp_status(0, 0, 0, 4'h1), "R9 enables readback", v, exp_status(0, 0, 0, 4'h1));
    host_wr(2'd0, 32'h2);
    #1 chk(evt == 1'b1, "R7 inbound write sets evt", 32'(evt), 1);
    repeat (2) @(negedge clk);
    #1 chk(evt == 1'b1, "R7 evt sticky", 32'(evt), 1);
    @(negedge clk); evt_ack = 1'b1;
    @(negedge clk); evt_ack = 1'b0;
    #1 chk(evt == 1'b0, "R7 evt_ack clears", 32'(evt), 0);
    core_rd(v);
    host_wr(2'd3, 32'h2);
    core_wr(2'd1, 32'h77);
    #1 chk(evt == 1'b0, "R7 core write alone leaves evt low", 32'(evt), 0);
    host_rd(2'd1, v);
    #1 chk(evt == 1'b1, "R7 host drain sets evt", 32'(evt), 1);
    @(negedge clk); evt_ack = 1'b1;
    @(negedge clk); evt_ack = 1'b0;
    core_wr(2'd2, 32'h88);
    #1 chk(irq == 1'b0, "R8 irq off when disabled", 32'(irq), 0);
    host_rd(2'd2, v);
    host_wr(2'd3, 32'h8);
    core_wr(2'd2, 32'h99);
    #1 chk(irq == 1'b1, "R8 irq on interrupt mailbox write", 32'(irq), 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    #1 chk(irq == 1'b0, "R8 irq_ack clears", 32'(irq), 0);
    host_rd(2'd2, v);
    chk(v == 32'h99, "R8 interrupt mailbox data", v, 32'h99);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_overflow();
    t_empty_stall();
    t_outbound();
    t_flags();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule